// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup

This block holds a red, a green and a blue 256-entry gamma table for each of several display channels. Each table maps one 8-bit colour code to another. Software fills the tables through a two-register write port: an address register that also carries an auto-step flag, and a data register that stores one 8-bit entry at the current address. Filling a table is a stream of data writes after a single address write.

Every pixel carries a channel tag. The block looks up its three components in that channel's tables when gamma is switched on for the channel. When gamma is off for the channel, the pixel passes through unchanged, which gives the same result as a linear table. The table memory loses its contents when gamma is off on every channel at once. A small state machine tracks this: tables count as live only after at least one data write has followed the re-enable, and until then every pixel bypasses the tables. Pixels come out with a fixed latency of two clock cycles.

States of the table keeper: TBL_SLEEP (gamma off on all channels; the reset state), TBL_STALE (some channel enabled, no data write seen since), TBL_LIVE (tables in use). Transitions: SLEEP to STALE when any enable bit is set. STALE to SLEEP when all enable bits are clear. STALE to LIVE on a data write while some enable bit is set. LIVE to SLEEP when all enable bits are clear.

Top module: `gamma_lut_mc`

## Requirements
- R1: After reset, out_valid is 0 and the keeper is in TBL_SLEEP.
- R2: The flat table address of entry i for colour k (0 red, 1 green, 2 blue) of channel c is c*768 + k*256 + i. A data write stores cfg_wdata[7:0] there.
- R3: A write with cfg_sel=0 loads the pointer from cfg_wdata[11:0] and the auto-step flag from cfg_wdata[31]. With the flag set, each data write (cfg_sel=1) advances the pointer by one.
- R4: With the auto-step flag clear, repeated data writes go to the same address, and the last one wins.
- R5: A pixel whose channel has its gamma_en bit clear leaves unchanged. Other channels keep using their tables.
- R6: A pixel presented with pix_valid appears on out_pix with out_valid exactly two cycles later. out_valid is low two cycles after a cycle without pix_valid.
- R7: When a table write and a lookup of the same entry happen in the same cycle, the lookup returns the old value, and the next lookup returns the new one.
- R8: While the keeper is in TBL_SLEEP or TBL_STALE, every pixel passes unchanged. Clearing all enable bits always leads to TBL_SLEEP. TBL_LIVE is entered only through a data write.
- R9: Data writes at pointer values of 2304 or above change no table entry. The pointer still steps past them.
- R10: A pixel tagged with a channel number of 3 or more passes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the data register |
| cfg_wdata | input | 32 | Write data: bit 31 auto-step and bits 11:0 pointer (address), or bits 7:0 entry (data) |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_chan | input | 2 | Channel tag of the input pixel |
| pix_in | input | 24 | Input pixel, red 23:16, green 15:8, blue 7:0 |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 24 | Output pixel, same packing as pix_in |

## Verification
The bench builds the block with its default parameters: three channels of 256-entry tables, 2304 entries in all. This size lets the bench write every entry in one auto-step stream and sweep all 256 codes of every channel against tables it computes arithmetically. The same configuration puts the last valid address (2303) and the first out-of-range one next to each other, and covers every keeper state, including the stale window right after a re-enable.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int CFG_W       = 32;
    localparam int STEP_BIT    = 31;
    localparam int N_COLOURS   = 3;
    localparam logic SEL_ADDR  = 1'b0;
    localparam logic SEL_DATA  = 1'b1;

    typedef enum logic [1:0] {
        TBL_SLEEP = 2'd0,
        TBL_STALE = 2'd1,
        TBL_LIVE  = 2'd2
    } tbl_state_e;
endpackage

// File: rtl/gamma_bank.sv
module gamma_bank #(
    parameter int DEPTH = 768,
    parameter int AW    = 10,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Read and write share one edge; nonblocking update gives old data on a collision.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/gamma_loader.sv
module gamma_loader
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 256,
    parameter int PTR_W     = 12,
    parameter int PIX_W     = 8,
    parameter int BANK_AW   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [N_COLOURS-1:0] bank_we,
    output logic [BANK_AW-1:0]   bank_waddr,
    output logic [PIX_W-1:0]     bank_wdata,
    output logic                 data_evt
);
    localparam int CH_SPAN = N_COLOURS * LUT_DEPTH;
    localparam int TOTAL   = NUM_CH * CH_SPAN;

    logic [PTR_W-1:0] ptr;
    logic             step_on;
    logic             addr_evt;
    logic             in_range;
    logic             unused_cfg_bits;

    assign addr_evt        = cfg_wr && (cfg_sel == SEL_ADDR);
    assign data_evt        = cfg_wr && (cfg_sel == SEL_DATA);
    assign bank_wdata      = cfg_wdata[PIX_W-1:0];
    assign unused_cfg_bits = ^cfg_wdata[STEP_BIT-1:PTR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            step_on <= 1'b0;
        end else if (addr_evt) begin
            ptr     <= cfg_wdata[PTR_W-1:0];
            step_on <= cfg_wdata[STEP_BIT];
        end else if (data_evt && step_on) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        int p;
        int ch;
        int rem;
        int col;
        int idx;
        p          = int'(ptr);
        in_range   = (p < TOTAL);
        ch         = p / CH_SPAN;
        rem        = p - ch * CH_SPAN;
        col        = rem / LUT_DEPTH;
        idx        = rem - col * LUT_DEPTH;
        bank_waddr = BANK_AW'(ch * LUT_DEPTH + idx);
        for (int k = 0; k < N_COLOURS; k++) begin
            bank_we[k] = data_evt && in_range && (col == k);
        end
    end

    // R3
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_evt && step_on) |=> (ptr == $past(ptr) + 1'b1));
    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_evt && !step_on) |=> (ptr == $past(ptr)));
    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));
    // R9
    range_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_evt && int'(ptr) >= TOTAL) |-> (bank_we == '0));
endmodule

// File: rtl/gamma_keeper.sv
module gamma_keeper
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              data_evt,
    output logic              tbl_live
);
    tbl_state_e state;
    tbl_state_e state_nx;
    logic       any_en;

    assign any_en = |gamma_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TBL_SLEEP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TBL_SLEEP: if (any_en) state_nx = TBL_STALE;
            TBL_STALE: begin
                if (!any_en)       state_nx = TBL_SLEEP;
                else if (data_evt) state_nx = TBL_LIVE;
            end
            TBL_LIVE:  if (!any_en) state_nx = TBL_SLEEP;
            default:   state_nx = TBL_SLEEP;
        endcase
    end

    always_comb begin
        unique case (state)
            TBL_LIVE: tbl_live = 1'b1;
            default:  tbl_live = 1'b0;
        endcase
    end

    // R8
    all_off_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gamma_en == '0) |=> (state == TBL_SLEEP));
    // R8
    live_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TBL_LIVE && !data_evt) |=> (state != TBL_LIVE));
endmodule

// File: rtl/gamma_lut_mc.sv
module gamma_lut_mc
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LUT_DEPTH = 256,
    parameter int PIX_W     = 8,
    parameter int PTR_W     = 12,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RGB_W    = N_COLOURS * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              pix_valid,
    input  logic [CH_W-1:0]   pix_chan,
    input  logic [RGB_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_pix
);
    localparam int BANK_DEPTH = NUM_CH * LUT_DEPTH;
    localparam int BANK_AW    = $clog2(BANK_DEPTH);
    localparam int CH_SLOTS   = 1 << CH_W;

    logic [N_COLOURS-1:0] bank_we;
    logic [BANK_AW-1:0]   bank_waddr;
    logic [PIX_W-1:0]     bank_wdata;
    logic                 data_evt;
    logic                 tbl_live;
    logic [CH_SLOTS-1:0]  en_slots;
    logic                 chan_ok;
    logic                 bypass_s0;

    logic                 valid_s1;
    logic                 bypass_s1;
    logic [RGB_W-1:0]     raw_s1;
    logic [RGB_W-1:0]     lut_s1;

    gamma_loader #(
        .NUM_CH(NUM_CH), .LUT_DEPTH(LUT_DEPTH), .PTR_W(PTR_W),
        .PIX_W(PIX_W), .BANK_AW(BANK_AW)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bank_we(bank_we), .bank_waddr(bank_waddr),
        .bank_wdata(bank_wdata), .data_evt(data_evt)
    );

    gamma_keeper #(.NUM_CH(NUM_CH)) u_keeper (
        .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en),
        .data_evt(data_evt), .tbl_live(tbl_live)
    );

    assign en_slots  = CH_SLOTS'(gamma_en);
    assign chan_ok   = int'(pix_chan) < NUM_CH;
    assign bypass_s0 = !tbl_live || !en_slots[pix_chan];

    for (genvar k = 0; k < N_COLOURS; k++) begin : g_colour
        localparam int LSB = (N_COLOURS - 1 - k) * PIX_W;
        logic [BANK_AW-1:0] raddr;

        assign raddr = chan_ok
            ? BANK_AW'(int'(pix_chan) * LUT_DEPTH + int'(pix_in[LSB +: PIX_W]))
            : '0;

        gamma_bank #(.DEPTH(BANK_DEPTH), .AW(BANK_AW), .DW(PIX_W)) u_bank (
            .clk(clk), .we(bank_we[k]), .waddr(bank_waddr), .wdata(bank_wdata),
            .raddr(raddr), .rdata(lut_s1[LSB +: PIX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s1  <= 1'b0;
            bypass_s1 <= 1'b1;
            raw_s1    <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            valid_s1  <= pix_valid;
            bypass_s1 <= bypass_s0;
            raw_s1    <= pix_in;
            out_valid <= valid_s1;
            out_pix   <= bypass_s1 ? raw_s1 : lut_s1;
        end
    end

    // R6
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ##2 out_valid);
    // R6
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ##2 !out_valid);
    // R5
    chan_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && chan_ok && !en_slots[pix_chan]) |-> ##2 (out_pix == $past(pix_in, 2)));
    // R10
    bad_tag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !chan_ok) |-> ##2 (out_pix == $past(pix_in, 2)));
    // R8
    not_live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !tbl_live) |-> ##2 (out_pix == $past(pix_in, 2)));
endmodule

// File: tb/test_gamma_lut_mc.sv
`timescale 1ns/1ps
module test_gamma_lut_mc;
    localparam int NUM_CH = 3;
    localparam int SPAN   = 768;
    localparam int TOTAL  = 2304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  gamma_en = '0;
    logic        pix_valid = 1'b0;
    logic [1:0]  pix_chan = '0;
    logic [23:0] pix_in = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    int checks = 0;
    int errors = 0;
    int tbl [TOTAL];
    bit live_m = 1'b0;

    always #2.5 clk = ~clk;

    gamma_lut_mc i_gamma_lut_mc (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .gamma_en(gamma_en), .pix_valid(pix_valid),
        .pix_chan(pix_chan), .pix_in(pix_in), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int fgen(input int c, input int k, input int i);
        return (i * (2 * k + 1) + 37 * c + 11 * k + 3) & 255;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic logic [23:0] expect_pix(input int c, input int r, input int g, input int b);
        bit byp;
        byp = (c >= NUM_CH) || !live_m;
        if (!byp) byp = (gamma_en[c] == 1'b0);
        if (byp) return {8'(r), 8'(g), 8'(b)};
        return {8'(tbl[c*SPAN + r]), 8'(tbl[c*SPAN + 256 + g]), 8'(tbl[c*SPAN + 512 + b])};
    endfunction

    task automatic look(input int c, input int r, input int g, input int b, input string req);
        logic [23:0] e;
        e = expect_pix(c, r, g, b);
        pix_valid = 1'b1; pix_chan = 2'(c); pix_in = {8'(r), 8'(g), 8'(b)};
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && out_pix == e, req, {7'd0, out_valid, out_pix}, {8'h01, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++)
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < 256; i++)
                    tbl[c*SPAN + k*256 + i] = fgen(c, k, i);

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_pix == '0, "R1", {7'd0, out_valid, out_pix}, 32'd0);
        // R8: sleeping keeper passes pixels
        look(0, 10, 20, 30, "R8");

        // R6: exact two-cycle latency
        gamma_en = 3'b111;
        @(negedge clk);
        pix_valid = 1'b1; pix_chan = 2'd1; pix_in = 24'h123456;
        @(negedge clk);
        pix_valid = 1'b0;
        chk(out_valid == 1'b0, "R6", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_pix == 24'h123456, "R6", {7'd0, out_valid, out_pix}, 32'h01123456);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6", {31'd0, out_valid}, 32'd0);

        // R8: stale after re-enable, before any data write
        look(2, 1, 2, 3, "R8");

        // R2 R3: stream every entry with auto-step
        wr(1'b0, 32'h8000_0000);
        for (int a = 0; a < TOTAL; a++) wr(1'b1, 32'(tbl[a]));
        live_m = 1'b1;
        for (int c = 0; c < NUM_CH; c++)
            for (int i = 0; i < 256; i++)
                look(c, i, (i + 85) & 255, 255 - i, "R2 R3");

        // R9: writes past the last entry are dropped
        tbl[TOTAL-1] = 8'h5A;
        wr(1'b0, 32'h8000_0000 | 32'(TOTAL - 1));
        wr(1'b1, 32'h5A);
        wr(1'b1, 32'hA5);
        wr(1'b0, 32'h8000_0FA0);
        wr(1'b1, 32'h77);
        look(2, 0, 0, 255, "R9");
        look(0, 0, 0, 0, "R9");
        look(2, 160, 0, 0, "R9");

        // R4: no auto-step, last write wins, neighbour untouched
        wr(1'b0, 32'd300);
        wr(1'b1, 32'h11);
        wr(1'b1, 32'h22);
        tbl[300] = 8'h22;
        look(0, 0, 44, 0, "R4");
        look(0, 0, 45, 0, "R4");

        // R5: channel 1 off, others still mapped
        gamma_en = 3'b101;
        @(negedge clk);
        for (int i = 0; i < 256; i++) look(1, i, 255 - i, (i * 7) & 255, "R5");
        look(0, 9, 9, 9, "R5");
        look(2, 9, 9, 9, "R5");

        // R10: unknown channel tag passes
        gamma_en = 3'b111;
        @(negedge clk);
        look(3, 200, 100, 50, "R10");

        // R7: write and lookup of the same entry in one cycle
        wr(1'b0, 32'd7);
        begin
            logic [23:0] e_old;
            e_old = expect_pix(0, 7, 7, 7);
            cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'hEE;
            pix_valid = 1'b1; pix_chan = 2'd0; pix_in = {8'd7, 8'd7, 8'd7};
            @(negedge clk);
            cfg_wr = 1'b0; pix_valid = 1'b0;
            @(negedge clk);
            chk(out_valid && out_pix == e_old, "R7", {7'd0, out_valid, out_pix}, {8'h01, e_old});
        end
        tbl[7] = 8'hEE;
        look(0, 7, 7, 7, "R7");

        // R8: all off, re-enable, stale until a data write
        gamma_en = 3'b000;
        live_m = 1'b0;
        @(negedge clk);
        look(0, 7, 7, 7, "R8");
        gamma_en = 3'b001;
        @(negedge clk);
        look(0, 7, 7, 7, "R8");
        wr(1'b1, 32'hEE);
        live_m = 1'b1;
        look(0, 7, 7, 7, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule